// File: doc/BRIEF.md
# GPIO Port Configuration and Output Register File

This block is the register side of a 16-pin general-purpose I/O port. A host reaches it over a simple synchronous word bus with address, write enable, write data, read enable and read data. It stores each pin's mode, output drive type, drive speed, pull selection, lock bits, alternate-function selections and analog-switch bits, and it holds the output data latch. Every stored value is brought out as a port, so a separate pin-level resolver can work out the pin state. The resolved input value comes back from that resolver and can be read through the bus.

The output latch can be written as a whole word. It can also be changed one bit at a time, without a read-modify-write, through two strobe locations. The first is a combined set/clear word, in which a set beats a clear on the same pin. The second is a clear-only word. The lock, alternate-function, speed and analog-switch values are only stored here; they have no effect inside this block. Writes commit on the clock edge. Read data and the error flag are combinational.

Top module: `gpio_port_regs`

## Requirements
- R1: On reset, mode, speed and pull take the values of the parameters MODE_RST, SPEED_RST and PULL_RST. Every other register, including the output latch, resets to zero.
- R2: The mode (offset 0x00), speed (0x08), pull (0x0C), alternate-function low (0x20) and alternate-function high (0x24) registers store and read back all 32 bits.
- R3: The drive-type (0x04), output-data (0x14), lock (0x1C) and analog-switch (0x2C) registers keep only write bits 15:0. Bits 31:16 read back as zero.
- R4: A write to the set/clear word (0x18) clears the output bits selected by write bits 31:16 and sets the output bits selected by write bits 15:0. When a pin is selected in both halves, it ends up set.
- R5: A write to the clear word (0x28) clears the output bits selected by write bits 15:0. Write bits 31:16 have no effect.
- R6: Reads of 0x18 and 0x28 return zero. Writes to them change only the output latch.
- R7: A read of 0x10 returns the resolver input `pinIn` in bits 15:0 and zero in the upper half. Writes to 0x10 change no register.
- R8: An access is unmapped when address bits 1:0 are not zero or the address is 0x30 or above. An unmapped read returns zero, an unmapped write changes no register, and `regErr` is high in the same cycle as any unmapped access.
- R9: A write takes effect at the rising clock edge on which `regWe` is sampled high. The configuration outputs show the new value from that edge on, and stay unchanged while `regWe` is low.
- R10: `regRdata` follows the address in the same cycle while `regRe` is high, and is zero while `regRe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 10 | Byte address within the 0x400 window |
| regWe | input | 1 | Write enable |
| regWdata | input | 32 | Write data |
| regRe | input | 1 | Read enable |
| regRdata | output | 32 | Read data, combinational |
| regErr | output | 1 | High during an access to an unmapped offset |
| pinIn | input | 16 | Resolved pin levels from the pin resolver |
| modeCfg | output | 32 | Two mode bits per pin |
| otypeCfg | output | 16 | Drive type per pin, 1 = open-drain |
| speedCfg | output | 32 | Stored drive-speed field |
| pullCfg | output | 32 | Two pull bits per pin |
| outData | output | 16 | Output data latch |
| lockCfg | output | 16 | Stored lock bits |
| afLoCfg | output | 32 | Alternate-function selection, pins 0-7 |
| afHiCfg | output | 32 | Alternate-function selection, pins 8-15 |
| analogCfg | output | 16 | Stored analog-switch bits |

## Verification
The bench aims at the set/clear word. In one case a pin is selected in both halves, and a design that gave the clear priority would drop that bit. Reserved upper halves are also checked: a design that missed the mask would read back write data in bits 31:16. The strobe locations are read back too, and a design that stored them would return non-zero. Misaligned and out-of-window writes are followed by reads of the register they would alias onto, which exposes a decoder that ignores the low address bits. Writes to the input location are checked against the live pin value, which exposes a register that latches the written word.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // word slots, address bits [5:2]; order fixed by the bus map
  localparam logic [3:0] SLOT_MODE  = 4'd0;
  localparam logic [3:0] SLOT_OTYPE = 4'd1;
  localparam logic [3:0] SLOT_SPEED = 4'd2;
  localparam logic [3:0] SLOT_PULL  = 4'd3;
  localparam logic [3:0] SLOT_IN    = 4'd4;
  localparam logic [3:0] SLOT_OUT   = 4'd5;
  localparam logic [3:0] SLOT_SETCL = 4'd6;
  localparam logic [3:0] SLOT_LOCK  = 4'd7;
  localparam logic [3:0] SLOT_AFLO  = 4'd8;
  localparam logic [3:0] SLOT_AFHI  = 4'd9;
  localparam logic [3:0] SLOT_CLR   = 4'd10;
  localparam logic [3:0] SLOT_ANLG  = 4'd11;
  localparam logic [3:0] SLOT_COUNT = 4'd12;

  typedef struct packed {
    logic mode;
    logic otype;
    logic speed;
    logic pull;
    logic outWord;
    logic setClr;
    logic lock;
    logic afLo;
    logic afHi;
    logic clrOnly;
    logic analog;
  } wrStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  output wrStrobe_t         wr,
  output logic [3:0]        rdSlot,
  output logic              rdHit,
  output logic              regErr
);
  localparam int SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slot;
  logic              mapped;
  logic              wrHit;

  assign slot   = regAddr[ADDR_W-1:2];
  assign mapped = (regAddr[1:0] == 2'b00) && (slot[SLOT_W-1:4] == '0) &&
                  (slot[3:0] < SLOT_COUNT);
  assign wrHit  = regWe && mapped;
  assign rdHit  = regRe && mapped;
  assign rdSlot = slot[3:0];
  assign regErr = (regWe || regRe) && !mapped;

  always_comb begin
    wr = '0;
    if (wrHit) begin
      case (slot[3:0])
        SLOT_MODE:  wr.mode    = 1'b1;
        SLOT_OTYPE: wr.otype   = 1'b1;
        SLOT_SPEED: wr.speed   = 1'b1;
        SLOT_PULL:  wr.pull    = 1'b1;
        SLOT_OUT:   wr.outWord = 1'b1;
        SLOT_SETCL: wr.setClr  = 1'b1;
        SLOT_LOCK:  wr.lock    = 1'b1;
        SLOT_AFLO:  wr.afLo    = 1'b1;
        SLOT_AFHI:  wr.afHi    = 1'b1;
        SLOT_CLR:   wr.clrOnly = 1'b1;
        SLOT_ANLG:  wr.analog  = 1'b1;
        default:    wr = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_dpath.sv
module gpio_port_dpath
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PINS  = 16,
  parameter logic [31:0] MODE_RST  = '0,
  parameter logic [31:0] SPEED_RST = '0,
  parameter logic [31:0] PULL_RST  = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wrStrobe_t             wr,
  input  logic [2*NUM_PINS-1:0] wdata,
  input  logic [3:0]            rdSlot,
  input  logic                  rdHit,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [2*NUM_PINS-1:0] rdata,
  output logic [2*NUM_PINS-1:0] modeQ,
  output logic [NUM_PINS-1:0]   otypeQ,
  output logic [2*NUM_PINS-1:0] speedQ,
  output logic [2*NUM_PINS-1:0] pullQ,
  output logic [NUM_PINS-1:0]   outQ,
  output logic [NUM_PINS-1:0]   lockQ,
  output logic [2*NUM_PINS-1:0] afLoQ,
  output logic [2*NUM_PINS-1:0] afHiQ,
  output logic [NUM_PINS-1:0]   analogQ
);
  localparam int WORD_W = 2 * NUM_PINS;
  localparam logic [NUM_PINS-1:0] HALF_ZERO = '0;

  logic [NUM_PINS-1:0] lowHalf;
  logic [NUM_PINS-1:0] highHalf;
  assign lowHalf  = wdata[NUM_PINS-1:0];
  assign highHalf = wdata[WORD_W-1:NUM_PINS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_RST;
      speedQ  <= SPEED_RST;
      pullQ   <= PULL_RST;
      otypeQ  <= '0;
      lockQ   <= '0;
      afLoQ   <= '0;
      afHiQ   <= '0;
      analogQ <= '0;
    end else begin
      if (wr.mode)   modeQ   <= wdata;
      if (wr.speed)  speedQ  <= wdata;
      if (wr.pull)   pullQ   <= wdata;
      if (wr.otype)  otypeQ  <= lowHalf;
      if (wr.lock)   lockQ   <= lowHalf;
      if (wr.afLo)   afLoQ   <= wdata;
      if (wr.afHi)   afHiQ   <= wdata;
      if (wr.analog) analogQ <= lowHalf;
    end
  end

  // one output latch bit per pin; set beats clear in the combined word
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_outBit
    logic bitQ;
    always_ff @(posedge clk) begin
      if (!rstN)                          bitQ <= 1'b0;
      else if (wr.outWord)                bitQ <= lowHalf[p];
      else if (wr.setClr && lowHalf[p])   bitQ <= 1'b1;
      else if (wr.setClr && highHalf[p])  bitQ <= 1'b0;
      else if (wr.clrOnly && lowHalf[p])  bitQ <= 1'b0;
    end
    assign outQ[p] = bitQ;
  end

  always_comb begin
    rdata = '0;
    if (rdHit) begin
      case (rdSlot)
        SLOT_MODE:  rdata = modeQ;
        SLOT_OTYPE: rdata = {HALF_ZERO, otypeQ};
        SLOT_SPEED: rdata = speedQ;
        SLOT_PULL:  rdata = pullQ;
        SLOT_IN:    rdata = {HALF_ZERO, pinIn};
        SLOT_OUT:   rdata = {HALF_ZERO, outQ};
        SLOT_LOCK:  rdata = {HALF_ZERO, lockQ};
        SLOT_AFLO:  rdata = afLoQ;
        SLOT_AFHI:  rdata = afHiQ;
        SLOT_ANLG:  rdata = {HALF_ZERO, analogQ};
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PINS  = 16,
  parameter int          ADDR_W    = 10,
  parameter logic [31:0] MODE_RST  = '0,
  parameter logic [31:0] SPEED_RST = '0,
  parameter logic [31:0] PULL_RST  = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWe,
  input  logic [2*NUM_PINS-1:0] regWdata,
  input  logic                  regRe,
  output logic [2*NUM_PINS-1:0] regRdata,
  output logic                  regErr,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [2*NUM_PINS-1:0] modeCfg,
  output logic [NUM_PINS-1:0]   otypeCfg,
  output logic [2*NUM_PINS-1:0] speedCfg,
  output logic [2*NUM_PINS-1:0] pullCfg,
  output logic [NUM_PINS-1:0]   outData,
  output logic [NUM_PINS-1:0]   lockCfg,
  output logic [2*NUM_PINS-1:0] afLoCfg,
  output logic [2*NUM_PINS-1:0] afHiCfg,
  output logic [NUM_PINS-1:0]   analogCfg
);
  wrStrobe_t  wr;
  logic [3:0] rdSlot;
  logic       rdHit;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .wr(wr), .rdSlot(rdSlot), .rdHit(rdHit), .regErr(regErr)
  );

  gpio_port_dpath #(
    .NUM_PINS(NUM_PINS), .MODE_RST(MODE_RST),
    .SPEED_RST(SPEED_RST), .PULL_RST(PULL_RST)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .wr(wr), .wdata(regWdata),
    .rdSlot(rdSlot), .rdHit(rdHit), .pinIn(pinIn), .rdata(regRdata),
    .modeQ(modeCfg), .otypeQ(otypeCfg), .speedQ(speedCfg), .pullQ(pullCfg),
    .outQ(outData), .lockQ(lockCfg), .afLoQ(afLoCfg), .afHiQ(afHiCfg),
    .analogQ(analogCfg)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     regAddr,
  input logic                  regWe,
  input logic [2*NUM_PINS-1:0] regWdata,
  input logic                  regRe,
  input logic [2*NUM_PINS-1:0] regRdata,
  input logic                  regErr,
  input logic [2*NUM_PINS-1:0] modeCfg,
  input logic [NUM_PINS-1:0]   outData
);
  localparam logic [ADDR_W-1:0] A_OTYPE = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_SETCL = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'('h30);

  logic offMap;
  assign offMap = (regAddr[1:0] != 2'b00) || (regAddr >= A_LIMIT);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_SETCL) |=>
      outData == (($past(outData) & ~$past(regWdata[2*NUM_PINS-1:NUM_PINS]))
                  | $past(regWdata[NUM_PINS-1:0])));

  assert_clear_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_CLR) |=>
      outData == ($past(outData) & ~$past(regWdata[NUM_PINS-1:0])));

  assert_strobe_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && (regAddr == A_SETCL || regAddr == A_CLR)) |-> regRdata == '0);

  assert_otype_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == A_OTYPE) |-> regRdata[2*NUM_PINS-1:NUM_PINS] == '0);

  assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    regErr == ((regWe || regRe) && offMap));

  assert_offmap_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && offMap) |=> ($stable(outData) && $stable(modeCfg)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> ($stable(outData) && $stable(modeCfg)));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regRe |-> regRdata == '0);
endmodule

bind gpio_port_regs gpio_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .regRe(regRe), .regRdata(regRdata), .regErr(regErr),
  .modeCfg(modeCfg), .outData(outData)
);

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
  localparam logic [31:0] MODE_RST  = 32'hABFF_0000;
  localparam logic [31:0] SPEED_RST = 32'h0C00_0000;
  localparam logic [31:0] PULL_RST  = 32'h6400_0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic        regRe = 1'b0;
  logic [31:0] regRdata;
  logic        regErr;
  logic [15:0] pinIn = '0;
  logic [31:0] modeCfg, speedCfg, pullCfg, afLoCfg, afHiCfg;
  logic [15:0] otypeCfg, outData, lockCfg, analogCfg;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  gpio_port_regs #(.MODE_RST(MODE_RST), .SPEED_RST(SPEED_RST), .PULL_RST(PULL_RST))
  i_gpio_port_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRe(regRe), .regRdata(regRdata), .regErr(regErr), .pinIn(pinIn),
    .modeCfg(modeCfg), .otypeCfg(otypeCfg), .speedCfg(speedCfg), .pullCfg(pullCfg),
    .outData(outData), .lockCfg(lockCfg), .afLoCfg(afLoCfg), .afHiCfg(afHiCfg),
    .analogCfg(analogCfg)
  );

  // entry: {isRead, reqNo[3:0], addr[9:0], data[31:0]}; data is write value or expected read
  localparam int NV = 30;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 4'd2, 10'h000, 32'h1234_5678}, {1'b1, 4'd2, 10'h000, 32'h1234_5678}, // R2
    {1'b0, 4'd2, 10'h008, 32'hCAFE_F00D}, {1'b1, 4'd2, 10'h008, 32'hCAFE_F00D}, // R2
    {1'b0, 4'd2, 10'h00C, 32'h5555_AAAA}, {1'b1, 4'd2, 10'h00C, 32'h5555_AAAA}, // R2
    {1'b0, 4'd2, 10'h020, 32'h1111_2222}, {1'b1, 4'd2, 10'h020, 32'h1111_2222}, // R2
    {1'b0, 4'd2, 10'h024, 32'h3333_4444}, {1'b1, 4'd2, 10'h024, 32'h3333_4444}, // R2
    {1'b0, 4'd3, 10'h004, 32'hFFFF_8001}, {1'b1, 4'd3, 10'h004, 32'h0000_8001}, // R3
    {1'b0, 4'd3, 10'h014, 32'hDEAD_1234}, {1'b1, 4'd3, 10'h014, 32'h0000_1234}, // R3
    {1'b0, 4'd3, 10'h01C, 32'h0001_FFFF}, {1'b1, 4'd3, 10'h01C, 32'h0000_FFFF}, // R3
    {1'b0, 4'd3, 10'h02C, 32'hABCD_0F0F}, {1'b1, 4'd3, 10'h02C, 32'h0000_0F0F}, // R3
    {1'b0, 4'd4, 10'h018, 32'h000F_00F0}, {1'b1, 4'd4, 10'h014, 32'h0000_12F0}, // R4
    {1'b0, 4'd4, 10'h018, 32'h00FF_00F0}, {1'b1, 4'd4, 10'h014, 32'h0000_12F0}, // R4 set wins
    {1'b0, 4'd5, 10'h028, 32'hFFFF_0230}, {1'b1, 4'd5, 10'h014, 32'h0000_10C0}, // R5
    {1'b1, 4'd6, 10'h028, 32'h0000_0000}, {1'b1, 4'd6, 10'h018, 32'h0000_0000}, // R6
    {1'b1, 4'd6, 10'h000, 32'h1234_5678}, {1'b1, 4'd6, 10'h004, 32'h0000_8001}, // R6 others kept
    {1'b1, 4'd6, 10'h01C, 32'h0000_FFFF}, {1'b1, 4'd6, 10'h02C, 32'h0000_0F0F}  // R6 others kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic doRead(input logic [9:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    regAddr = a; regRe = 1'b1;
    #1;
    d = regRdata; e = regErr;
    regRe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    doRead(10'h000, rd, er); check("R1 mode", rd, MODE_RST);
    doRead(10'h008, rd, er); check("R1 speed", rd, SPEED_RST);
    doRead(10'h00C, rd, er); check("R1 pull", rd, PULL_RST);
    doRead(10'h004, rd, er); check("R1 otype", rd, 32'h0);
    doRead(10'h020, rd, er); check("R1 afLo", rd, 32'h0);
    check("R1 outData", {16'h0, outData}, 32'h0);
    check("R1 lock+analog", {lockCfg, analogCfg}, 32'h0);

    // R10 read enable low gives zero
    @(negedge clk); regAddr = 10'h000; regRe = 1'b0; #1;
    check("R10 idle read", regRdata, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46]) begin
        doRead(VEC[i][41:32], rd, er);
        check($sformatf("R%0d vector %0d", VEC[i][45:42], i), rd, VEC[i][31:0]);
      end else begin
        doWrite(VEC[i][41:32], VEC[i][31:0]);
      end
    end

    // R9 write edge timing: old value before edge, new after
    @(negedge clk);
    regAddr = 10'h014; regWdata = 32'h0000_0F0F; regWe = 1'b1;
    #1; check("R9 before edge", {16'h0, outData}, 32'h0000_10C0);
    @(negedge clk); regWe = 1'b0;
    check("R9 after edge", {16'h0, outData}, 32'h0000_0F0F);
    @(negedge clk); check("R9 held", {16'h0, outData}, 32'h0000_0F0F);

    // R7 input location
    pinIn = 16'hA5C3;
    doRead(10'h010, rd, er); check("R7 pin read", rd, 32'h0000_A5C3);
    doWrite(10'h010, 32'hFFFF_FFFF);
    doRead(10'h010, rd, er); check("R7 after write", rd, 32'h0000_A5C3);
    check("R7 out unchanged", {16'h0, outData}, 32'h0000_0F0F);

    // R8 unmapped accesses
    @(negedge clk);
    regAddr = 10'h015; regWdata = 32'hFFFF_FFFF; regWe = 1'b1;
    #1; check("R8 err on misaligned write", {31'h0, regErr}, 32'h1);
    @(negedge clk); regWe = 1'b0;
    doRead(10'h014, rd, er); check("R8 misaligned write ignored", rd, 32'h0000_0F0F);
    doWrite(10'h030, 32'hFFFF_FFFF);
    doWrite(10'h3FC, 32'hFFFF_FFFF);
    doRead(10'h000, rd, er); check("R8 mode unchanged", rd, 32'h1234_5678);
    doRead(10'h030, rd, er);
    check("R8 unmapped read", rd, 32'h0);
    check("R8 err on read", {31'h0, er}, 32'h1);
    doRead(10'h02C, rd, er); check("R8 no err mapped", {31'h0, er}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule